// File: doc/BRIEF.md
# Receive Descriptor and Status Ring Manager

This block sits beside a receive DMA engine and owns two circular rings held in a word-addressed memory. The free-buffer ring is filled by software with two-word descriptors (buffer address, then a word carrying the buffer index and buffer length). The completion ring receives one two-word status entry per finished frame. Software gives the base byte address and byte length of each ring, and returns entries to the block by writing counts, not producer pointers.

A completed frame arrives as a single-cycle strobe with its length and an error flag. When both rings hold credit, the block reads the descriptor at the free-ring pointer to learn the buffer index. It writes a status entry that hands that index back with the frame length, then advances both pointers and raises the receive-status interrupt. A frame that finds no credit, or that arrives while a previous frame is still being written, is dropped and counted. Software reads the current pointers to find the newest status entry.

Top module: `rxq_mgr`

## Requirements
- R1: After reset both current pointers equal their base inputs, the interrupt and the receive-active flag are 0, the miss counter is 0 and both rings have no credit.
- R2: `rx_active_o` is 1 one clock after `rx_en_i` is sampled high and 0 one clock after it is sampled low.
- R3: For an accepted frame the block reads descriptor word 1 at free-ring pointer + 4, where bits 30:16 are the buffer index. It writes status word 0 at completion-ring pointer and status word 1 at pointer + 4; word 1 is {1'b0, index[14:0], frame length[15:0]}.
- R4: Each accepted frame advances both pointers by 8 bytes. A pointer that would reach base + byte length returns to base.
- R5: A pulse on a ring's enqueue write adds the given count of credits to that ring, and each accepted frame uses one credit from each ring.
- R6: A frame that finds zero credit in either ring writes no memory, leaves both pointers unchanged and increments the 32-bit miss counter by 1.
- R7: A frame strobe that arrives while an earlier frame is still being processed is dropped and increments the miss counter by 1.
- R8: While `rx_en_i` is 0 a frame strobe is ignored: no write, no pointer move, no miss count.
- R9: `irq_rx_o` becomes 1 when a status entry has been written and stays 1 until a pulse on `irq_rd_i` clears it; a set in the same cycle wins.
- R10: Status word 0 has bit 31 (processed), bit 29 (end of frame) and bit 28 (end of buffer) set, bit 30 equal to the inverse of the error flag, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| rx_active_o | output | 1 | Receive-active flag |
| desc_base_i | input | AW | Free-buffer ring base byte address |
| desc_len_i | input | AW | Free-buffer ring byte length |
| sts_base_i | input | AW | Completion ring base byte address |
| sts_len_i | input | AW | Completion ring byte length |
| desc_enq_we_i | input | 1 | Add credits to free-buffer ring |
| desc_enq_cnt_i | input | CW | Credits to add to free-buffer ring |
| sts_enq_we_i | input | 1 | Add credits to completion ring |
| sts_enq_cnt_i | input | CW | Credits to add to completion ring |
| frame_done_i | input | 1 | Frame-complete strobe |
| frame_len_i | input | 16 | Frame length in bytes |
| frame_err_i | input | 1 | Frame received with error |
| mem_addr_o | output | AW | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, combinational from mem_addr_o |
| desc_cur_o | output | AW | Free-buffer ring current pointer |
| sts_cur_o | output | AW | Completion ring current pointer |
| irq_rx_o | output | 1 | Receive-status interrupt |
| irq_rd_i | input | 1 | Clear-on-read strobe for the interrupt |
| miss_cnt_o | output | 32 | Dropped-frame counter |

## Verification
A frame strobe sampled at clock edge E0 yields the descriptor read in the next cycle. Status word 0 is written at edge E2 and word 1 at E3. At E3 the pointers, the interrupt and the credits update, so every per-frame check is made at the falling edge after E3. A miss shows in the counter one edge after the strobe, receive-active one edge after the enable, and an interrupt clear one edge after the read strobe. Inputs change on falling edges and outputs are sampled on falling edges, a whole number of cycles after each stimulus.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RDD, ST_WS0, ST_WS1} rxq_state_e;
  localparam int ENTRY_BYTES  = 8;
  localparam int STS_PROC_BIT = 31;
  localparam int STS_OK_BIT   = 30;
  localparam int STS_EOF_BIT  = 29;
  localparam int STS_EOB_BIT  = 28;
  localparam int IDX_LSB      = 16;
endpackage

// File: rtl/rxq_ring_ptr.sv
module rxq_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_o
);
  import rxq_pkg::*;
  logic [AW-1:0] off_q, off_nxt;

  always_comb begin
    off_nxt = off_q + AW'(ENTRY_BYTES);
    if (off_nxt >= len_i) off_nxt = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    off_q <= '0;
    else if (adv_i) off_q <= off_nxt;
  end

  assign cur_o = base_i + off_q;
endmodule

// File: rtl/rxq_credit.sv
module rxq_credit #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          add_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          take_i,
  output logic          avail_o
);
  logic [CW-1:0] cred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cred_q <= '0;
    else         cred_q <= cred_q + (add_i ? cnt_i : '0) - CW'(take_i);
  end

  assign avail_o = (cred_q != '0);
endmodule

// File: rtl/rxq_mgr.sv
module rxq_mgr #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int LW = 16,
  parameter int IW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  output logic          rx_active_o,
  input  logic [AW-1:0] desc_base_i,
  input  logic [AW-1:0] desc_len_i,
  input  logic [AW-1:0] sts_base_i,
  input  logic [AW-1:0] sts_len_i,
  input  logic          desc_enq_we_i,
  input  logic [CW-1:0] desc_enq_cnt_i,
  input  logic          sts_enq_we_i,
  input  logic [CW-1:0] sts_enq_cnt_i,
  input  logic          frame_done_i,
  input  logic [LW-1:0] frame_len_i,
  input  logic          frame_err_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic [AW-1:0] desc_cur_o,
  output logic [AW-1:0] sts_cur_o,
  output logic          irq_rx_o,
  input  logic          irq_rd_i,
  output logic [31:0]   miss_cnt_o
);
  import rxq_pkg::*;

  rxq_state_e    state_q;
  logic [LW-1:0] len_q;
  logic          err_q;
  logic [IW-1:0] idx_q;
  logic          desc_ok, sts_ok, accept, miss, done;
  logic          act_q, irq_q;
  logic [31:0]   miss_q;

  assign accept = frame_done_i && rx_en_i && state_q == ST_IDLE && desc_ok && sts_ok;
  assign miss   = frame_done_i && rx_en_i && !accept;
  assign done   = (state_q == ST_WS1);

  rxq_ring_ptr #(.AW(AW)) u_desc_ptr (
    .clk_i, .rst_ni, .base_i(desc_base_i), .len_i(desc_len_i), .adv_i(done), .cur_o(desc_cur_o));
  rxq_ring_ptr #(.AW(AW)) u_sts_ptr (
    .clk_i, .rst_ni, .base_i(sts_base_i), .len_i(sts_len_i), .adv_i(done), .cur_o(sts_cur_o));
  rxq_credit #(.CW(CW)) u_desc_cred (
    .clk_i, .rst_ni, .add_i(desc_enq_we_i), .cnt_i(desc_enq_cnt_i), .take_i(done), .avail_o(desc_ok));
  rxq_credit #(.CW(CW)) u_sts_cred (
    .clk_i, .rst_ni, .add_i(sts_enq_we_i), .cnt_i(sts_enq_cnt_i), .take_i(done), .avail_o(sts_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      err_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RDD;
          len_q   <= frame_len_i;
          err_q   <= frame_err_i;
        end
        ST_RDD: begin
          idx_q   <= mem_rdata_i[IDX_LSB +: IW];
          state_q <= ST_WS0;
        end
        ST_WS0:  state_q <= ST_WS1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = 1'b0;
    mem_wdata_o = '0;
    mem_addr_o  = desc_cur_o + AW'(4);
    if (state_q == ST_WS0) begin
      mem_we_o    = 1'b1;
      mem_addr_o  = sts_cur_o;
      mem_wdata_o[STS_PROC_BIT] = 1'b1;
      mem_wdata_o[STS_OK_BIT]   = !err_q;
      mem_wdata_o[STS_EOF_BIT]  = 1'b1;
      mem_wdata_o[STS_EOB_BIT]  = 1'b1;
    end else if (state_q == ST_WS1) begin
      mem_we_o    = 1'b1;
      mem_addr_o  = sts_cur_o + AW'(4);
      mem_wdata_o = (32'(idx_q) << IDX_LSB) | 32'(len_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      irq_q  <= 1'b0;
      miss_q <= '0;
    end else begin
      act_q <= rx_en_i;
      if (done)          irq_q <= 1'b1;
      else if (irq_rd_i) irq_q <= 1'b0;
      if (miss) miss_q <= miss_q + 32'd1;
    end
  end

  assign rx_active_o = act_q;
  assign irq_rx_o    = irq_q;
  assign miss_cnt_o  = miss_q;
endmodule

// File: rtl/rxq_mgr_chk.sv
module rxq_mgr_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_en_i,
  input logic          rx_active_o,
  input logic [AW-1:0] desc_base_i,
  input logic [AW-1:0] desc_cur_o,
  input logic [AW-1:0] sts_base_i,
  input logic [AW-1:0] sts_cur_o,
  input logic          irq_rx_o,
  input logic          irq_rd_i,
  input logic [31:0]   miss_cnt_o
);
  // R2
  active_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i |=> rx_active_o);
  // R2
  active_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !rx_active_o);
  // R4
  desc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(desc_base_i) && desc_cur_o != $past(desc_cur_o)) |->
      (desc_cur_o == $past(desc_cur_o) + AW'(8) || desc_cur_o == desc_base_i));
  // R4
  sts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(sts_base_i) && sts_cur_o != $past(sts_cur_o)) |->
      (sts_cur_o == $past(sts_cur_o) + AW'(8) || sts_cur_o == sts_base_i));
  // R6
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != $past(miss_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o) + 32'd1));
  // R9
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_rx_o) |-> $past(irq_rd_i));
endmodule

bind rxq_mgr rxq_mgr_chk #(.AW(AW)) i_rxq_mgr_chk (
  .clk_i, .rst_ni, .rx_en_i, .rx_active_o, .desc_base_i, .desc_cur_o,
  .sts_base_i, .sts_cur_o, .irq_rx_o, .irq_rd_i, .miss_cnt_o);

// File: tb/test_rxq_mgr.sv
`timescale 1ns/1ps
module test_rxq_mgr;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam logic [31:0] DBASE = 32'h0, DLEN = 32'd32, SBASE = 32'h40, SLEN = 32'd24;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_en = 1'b0, rx_active;
  logic desc_we = 1'b0, sts_we = 1'b0;
  logic [CW-1:0] desc_cnt = '0, sts_cnt = '0;
  logic frame_done = 1'b0, frame_err = 1'b0;
  logic [15:0] frame_len = '0;
  logic [AW-1:0] mem_addr, desc_cur, sts_cur;
  logic mem_we, irq, irq_rd = 1'b0;
  logic [31:0] mem_wdata, mem_rdata, miss_cnt;
  logic [31:0] mem [64];
  int n_chk = 0, n_bad = 0, k = 0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

  rxq_mgr #(.AW(AW), .CW(CW)) i_rxq_mgr (
    .clk_i(clk), .rst_ni, .rx_en_i(rx_en), .rx_active_o(rx_active),
    .desc_base_i(DBASE), .desc_len_i(DLEN), .sts_base_i(SBASE), .sts_len_i(SLEN),
    .desc_enq_we_i(desc_we), .desc_enq_cnt_i(desc_cnt),
    .sts_enq_we_i(sts_we), .sts_enq_cnt_i(sts_cnt),
    .frame_done_i(frame_done), .frame_len_i(frame_len), .frame_err_i(frame_err),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .desc_cur_o(desc_cur), .sts_cur_o(sts_cur), .irq_rx_o(irq), .irq_rd_i(irq_rd),
    .miss_cnt_o(miss_cnt));

  // {err, len}
  localparam logic [16:0] VEC [5] = '{
    {1'b0, 16'd64}, {1'b1, 16'd1518}, {1'b0, 16'd1}, {1'b0, 16'hFFFF}, {1'b1, 16'd300}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic strobe(input logic err, input logic [15:0] len);
    @(negedge clk);
    frame_done = 1'b1; frame_err = err; frame_len = len;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic enq(input logic [CW-1:0] d, input logic [CW-1:0] s);
    @(negedge clk);
    desc_we = (d != 0); desc_cnt = d; sts_we = (s != 0); sts_cnt = s;
    @(negedge clk);
    desc_we = 1'b0; sts_we = 1'b0;
  endtask

  // full accepted frame with R3/R4/R9/R10 checks; k counts accepted frames
  task automatic good_frame(input logic err, input logic [15:0] len);
    int e, s;
    e = k % 4; s = k % 3;
    strobe(err, len);
    repeat (3) @(negedge clk);
    chk("R10 status word0", mem[16 + 2*s], {1'b1, ~err, 1'b1, 1'b1, 28'h0});
    chk("R3 status word1", mem[17 + 2*s], {1'b0, 15'(e + 5), len});
    k++;
    chk("R4 desc pointer", desc_cur, DBASE + 32'(8 * (k % 4)));
    chk("R4 sts pointer", sts_cur, SBASE + 32'(8 * (k % 3)));
    chk("R9 irq set", {31'h0, irq}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    for (int e = 0; e < 4; e++) begin
      mem[2*e]     = 32'h1000 * 32'(e + 1);
      mem[2*e + 1] = {1'b0, 15'(e + 5), 16'h0600};
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 desc pointer", desc_cur, DBASE);
    chk("R1 sts pointer", sts_cur, SBASE);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 miss", miss_cnt, 32'h0);
    chk("R1 active", {31'h0, rx_active}, 32'h0);

    // R1: no credit yet, frame is a miss
    rx_en = 1'b1;
    @(negedge clk);
    chk("R2 active rises", {31'h0, rx_active}, 32'h1);
    strobe(1'b0, 16'd10);
    chk("R1 no credit miss", miss_cnt, 32'h1);
    chk("R6 desc unchanged", desc_cur, DBASE);

    enq(8'd8, 8'd8);
    foreach (VEC[i]) good_frame(VEC[i][16], VEC[i][15:0]);

    @(negedge clk); irq_rd = 1'b1;
    @(negedge clk); irq_rd = 1'b0;
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);

    // R7: second strobe while busy
    @(negedge clk);
    frame_done = 1'b1; frame_err = 1'b0; frame_len = 16'd77;
    @(negedge clk);
    frame_len = 16'd99;
    @(negedge clk);
    frame_done = 1'b0;
    chk("R7 busy miss", miss_cnt, 32'h2);
    repeat (2) @(negedge clk);
    chk("R7 first frame kept", mem[17 + 2*(k % 3)], {1'b0, 15'((k % 4) + 5), 16'd77});
    k++;
    chk("R7 sts pointer", sts_cur, SBASE + 32'(8 * (k % 3)));

    // R5: two credits left of eight
    good_frame(1'b0, 16'd500);
    good_frame(1'b0, 16'd501);
    strobe(1'b0, 16'd502);
    repeat (3) @(negedge clk);
    chk("R5 credits exhausted miss", miss_cnt, 32'h3);
    chk("R6 desc unchanged", desc_cur, DBASE + 32'(8 * (k % 4)));
    chk("R6 sts unchanged", sts_cur, SBASE + 32'(8 * (k % 3)));

    // R5: one ring credited only
    enq(8'd1, 8'd0);
    strobe(1'b0, 16'd503);
    chk("R5 status ring empty miss", miss_cnt, 32'h4);
    enq(8'd0, 8'd1);
    good_frame(1'b1, 16'd504);
    chk("R5 no further miss", miss_cnt, 32'h4);

    // R8
    rx_en = 1'b0;
    @(negedge clk);
    chk("R2 active falls", {31'h0, rx_active}, 32'h0);
    enq(8'd1, 8'd1);
    strobe(1'b0, 16'd600);
    repeat (3) @(negedge clk);
    chk("R8 miss unchanged", miss_cnt, 32'h4);
    chk("R8 sts unchanged", sts_cur, SBASE + 32'(8 * (k % 3)));
    chk("R8 desc unchanged", desc_cur, DBASE + 32'(8 * (k % 4)));

    finish_run();
  end
endmodule